// File: doc/BRIEF.md
# USB Interrupt Flag Aggregator

This block gathers single-cycle event pulses from a USB function controller into three flag registers: one for device-wide events such as suspend, resume, bus reset and start-of-frame; one for the bidirectional control endpoint together with every IN endpoint; and one for every OUT endpoint. Each flag register has its own enable mask. A flag bit records its event whatever the state of its mask. Reading a flag register returns its contents and empties it in the same access, so software should keep a copy of what it read.

The USB sources share one CPU interrupt vector with a general-purpose port's input interrupts. The block therefore also holds that port's flag and mask registers, and merges all masked sources into one sticky shared CPU flag. An interrupt request leaves the block only when the global enable bit is also set. One port flag bit is fed by a falling-edge detector on the USB D+ line, sampled through a synchronizer, which signals a resume from suspend. Software clears the port flags first and the shared flag after them. The shared flag comes back at once if any masked source is still pending.

Top module: `usb_irq_agg`

## Requirements
- R1: An event pulse sets its flag bit at the next clock edge, whether or not the matching mask bit is 1. Events `ev_common`, `ev_in` and `ev_out` feed the flag registers at addresses 0, 1 and 2 respectively, bit for bit.
- R2: A read (`bus_rd`) at address 0, 1 or 2 returns the register's current value on `bus_rdata` in that cycle and clears the whole register at the clock edge. The other flag registers are left untouched.
- R3: When an event arrives in the same cycle as the read-clear of its register, the read returns the old value and the new event's bit is set after the edge.
- R4: The mask registers at addresses 3, 4 and 5 (common, IN, OUT) read and write on the low bits of the bus. After reset every mask bit is 1 except the start-of-frame enable (common bit 3) and the suspend enable (common bit 0), so the common mask reads 0x36.
- R5: The shared CPU flag `cpu_flag` rises one clock edge after any flag bit is set with its mask bit at 1, in any of the four flag registers. It stays 0 when every set flag is masked off.
- R6: A write of any value to address 9 clears `cpu_flag`. If a masked source is still pending, the flag stays 1. A read of address 9 returns the flag in bit 0.
- R7: `irq_req` is 1 exactly when `cpu_flag` is 1 and the global enable (address 8, bit 0, reset 0) is 1.
- R8: The D+ input passes through a two-flop synchronizer. A high-to-low change sets port flag bit 7 (address 6) at the third clock edge after the change. A rising change sets nothing. `port_ev[7]` has no effect.
- R9: Port events `port_ev[6:0]` set port flag bits 6..0. Writing 1s to address 6 clears those bits. The port mask at address 7 resets to 0.
- R10: Reads of unused addresses (10 to 15) return 0. Writes to addresses 0 to 2 do not change the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_common | input | NC | Device-wide event pulses |
| ev_in | input | NI | Control endpoint and IN endpoint event pulses |
| ev_out | input | NO | OUT endpoint event pulses |
| port_ev | input | NP | Port input event pulses (D+ bit ignored) |
| dp_pin | input | 1 | Asynchronous D+ line level |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational from address |
| cpu_flag | output | 1 | Shared CPU interrupt flag |
| irq_req | output | 1 | Interrupt request to the CPU |

## Verification
Two functions can fall in the same cycle. One is a read that clears a flag register while new event pulses arrive for that same register. The other is a clear of the shared CPU flag while a masked source is still pending. Directed cases set both up on purpose: a read is issued with events on the read register, and the shared flag is cleared before the flags are drained and again after. A long random run then produces both overlaps by chance many times. Each cycle is compared against a bench model that applies set-over-clear for the flags and pending-over-clear for the shared flag.

// File: rtl/usbirq_pkg.sv
package usbirq_pkg;
   localparam int ADDR_W = 4;

   typedef enum logic [ADDR_W-1:0] {
      RA_EVC = 4'd0,
      RA_EVI = 4'd1,
      RA_EVO = 4'd2,
      RA_MKC = 4'd3,
      RA_MKI = 4'd4,
      RA_MKO = 4'd5,
      RA_PFL = 4'd6,
      RA_PMK = 4'd7,
      RA_GEN = 4'd8,
      RA_CPF = 4'd9
   } reg_addr_e;

   typedef enum logic {
      CLR_ON_READ,
      CLR_ON_WRITE1
   } clr_mode_e;
endpackage

// File: rtl/usbirq_flagbank.sv
module usbirq_flagbank
   import usbirq_pkg::*;
#(
   parameter int        W    = 8,
   parameter clr_mode_e MODE = CLR_ON_READ
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic         clr_rd_i,
   input  logic [W-1:0] clr_w1c_i,
   output logic [W-1:0] flags_o
);
   logic [W-1:0] clr_vec;
   logic [W-1:0] flag_q;

   if (W < 1) begin : g_bad_w
      $error("usbirq_flagbank: W must be at least 1");
   end

   // Clearing variant picked by parameter
   if (MODE == CLR_ON_READ) begin : g_rdclr
      logic unused_w1c;
      assign unused_w1c = ^clr_w1c_i;
      assign clr_vec    = {W{clr_rd_i}};
   end else begin : g_w1c
      logic unused_rd;
      assign unused_rd = clr_rd_i;
      assign clr_vec   = clr_w1c_i;
   end

   // Set wins over clear in every bit
   for (genvar i = 0; i < W; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flag_q[i] <= 1'b0;
         else        flag_q[i] <= set_i[i] | (flag_q[i] & ~clr_vec[i]);
      end
   end

   assign flags_o = flag_q;
endmodule

// File: rtl/usbirq_maskreg.sv
module usbirq_maskreg #(
   parameter int         W   = 8,
   parameter logic [W-1:0] RST = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] mask_o
);
   logic [W-1:0] mask_q;

   if (W < 1) begin : g_bad_w
      $error("usbirq_maskreg: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    mask_q <= RST;
      else if (we_i) mask_q <= wdata_i;
   end

   assign mask_o = mask_q;
endmodule

// File: rtl/usbirq_sync_edge.sv
module usbirq_sync_edge #(
   parameter int   STAGES    = 2,
   parameter logic IDLE_LVL  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic fall_o
);
   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("usbirq_sync_edge: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[0] <= IDLE_LVL;
      else        sync_q[0] <= pin_i;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q[s] <= IDLE_LVL;
         else        sync_q[s] <= sync_q[s-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= IDLE_LVL;
      else        prev_q <= sync_q[STAGES-1];
   end

   assign fall_o = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/usbirq_combine.sv
module usbirq_combine #(
   parameter int NC = 6,
   parameter int NI = 6,
   parameter int NO = 6,
   parameter int NP = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NC-1:0] cflag_i,
   input  logic [NC-1:0] cmask_i,
   input  logic [NI-1:0] iflag_i,
   input  logic [NI-1:0] imask_i,
   input  logic [NO-1:0] oflag_i,
   input  logic [NO-1:0] omask_i,
   input  logic [NP-1:0] pflag_i,
   input  logic [NP-1:0] pmask_i,
   input  logic          cpf_clr_i,
   input  logic          gen_i,
   output logic          pending_o,
   output logic          cpu_flag_o,
   output logic          irq_o
);
   logic usb_pend;
   logic port_pend;
   logic cpf_q;

   assign usb_pend  = (|(cflag_i & cmask_i)) | (|(iflag_i & imask_i)) |
                      (|(oflag_i & omask_i));
   assign port_pend = |(pflag_i & pmask_i);
   assign pending_o = usb_pend | port_pend;

   // Pending source re-asserts over a software clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cpf_q <= 1'b0;
      else        cpf_q <= pending_o | (cpf_q & ~cpf_clr_i);
   end

   assign cpu_flag_o = cpf_q;
   assign irq_o      = cpf_q & gen_i;
endmodule

// File: rtl/usb_irq_agg.sv
module usb_irq_agg
   import usbirq_pkg::*;
#(
   parameter int NC       = 6,
   parameter int NI       = 6,
   parameter int NO       = 6,
   parameter int NP       = 8,
   parameter int DW       = 8,
   parameter int SOF_BIT  = 3,
   parameter int SUSP_BIT = 0,
   parameter int DP_BIT   = 7,
   parameter int SYNC_N   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NC-1:0]     ev_common,
   input  logic [NI-1:0]     ev_in,
   input  logic [NO-1:0]     ev_out,
   input  logic [NP-1:0]     port_ev,
   input  logic              dp_pin,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   output logic              cpu_flag,
   output logic              irq_req
);
   localparam logic [NC-1:0] CMSK_RST =
      ~((NC'(1) << SOF_BIT) | (NC'(1) << SUSP_BIT));
   localparam logic [NP-1:0] DP_SEL = NP'(1) << DP_BIT;

   if (NC > DW || NI > DW || NO > DW || NP > DW) begin : g_bad_width
      $error("usb_irq_agg: flag registers must fit in the data bus");
   end
   if (SOF_BIT >= NC || SUSP_BIT >= NC || SOF_BIT == SUSP_BIT) begin : g_bad_cbits
      $error("usb_irq_agg: bad start-of-frame or suspend bit position");
   end
   if (DP_BIT >= NP) begin : g_bad_dp
      $error("usb_irq_agg: D+ flag bit outside port register");
   end

   logic [NC-1:0] cflag, cmask;
   logic [NI-1:0] iflag, imask;
   logic [NO-1:0] oflag, omask;
   logic [NP-1:0] pflag, pmask, pset, pclr;
   logic          gen_q;
   logic          dp_fall;
   logic          pending;
   logic          rd_evc, rd_evi, rd_evo;
   logic          wr_mkc, wr_mki, wr_mko, wr_pfl, wr_pmk, wr_gen, wr_cpf;
   logic          unused_wd;

   assign unused_wd = ^bus_wdata;

   // Access decode
   assign rd_evc = bus_rd && (bus_addr == RA_EVC);
   assign rd_evi = bus_rd && (bus_addr == RA_EVI);
   assign rd_evo = bus_rd && (bus_addr == RA_EVO);
   assign wr_mkc = bus_wr && (bus_addr == RA_MKC);
   assign wr_mki = bus_wr && (bus_addr == RA_MKI);
   assign wr_mko = bus_wr && (bus_addr == RA_MKO);
   assign wr_pfl = bus_wr && (bus_addr == RA_PFL);
   assign wr_pmk = bus_wr && (bus_addr == RA_PMK);
   assign wr_gen = bus_wr && (bus_addr == RA_GEN);
   assign wr_cpf = bus_wr && (bus_addr == RA_CPF);

   // D+ resume edge
   usbirq_sync_edge #(.STAGES(SYNC_N), .IDLE_LVL(1'b1)) u_dp (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (dp_pin),
      .fall_o (dp_fall)
   );

   assign pset = (port_ev & ~DP_SEL) | (dp_fall ? DP_SEL : '0);
   assign pclr = wr_pfl ? bus_wdata[NP-1:0] : '0;

   // Flag registers
   usbirq_flagbank #(.W(NC), .MODE(CLR_ON_READ)) u_cflag (
      .clk(clk), .rst_n(rst_n), .set_i(ev_common), .clr_rd_i(rd_evc),
      .clr_w1c_i('0), .flags_o(cflag)
   );
   usbirq_flagbank #(.W(NI), .MODE(CLR_ON_READ)) u_iflag (
      .clk(clk), .rst_n(rst_n), .set_i(ev_in), .clr_rd_i(rd_evi),
      .clr_w1c_i('0), .flags_o(iflag)
   );
   usbirq_flagbank #(.W(NO), .MODE(CLR_ON_READ)) u_oflag (
      .clk(clk), .rst_n(rst_n), .set_i(ev_out), .clr_rd_i(rd_evo),
      .clr_w1c_i('0), .flags_o(oflag)
   );
   usbirq_flagbank #(.W(NP), .MODE(CLR_ON_WRITE1)) u_pflag (
      .clk(clk), .rst_n(rst_n), .set_i(pset), .clr_rd_i(1'b0),
      .clr_w1c_i(pclr), .flags_o(pflag)
   );

   // Mask registers
   usbirq_maskreg #(.W(NC), .RST(CMSK_RST)) u_cmask (
      .clk(clk), .rst_n(rst_n), .we_i(wr_mkc),
      .wdata_i(bus_wdata[NC-1:0]), .mask_o(cmask)
   );
   usbirq_maskreg #(.W(NI), .RST({NI{1'b1}})) u_imask (
      .clk(clk), .rst_n(rst_n), .we_i(wr_mki),
      .wdata_i(bus_wdata[NI-1:0]), .mask_o(imask)
   );
   usbirq_maskreg #(.W(NO), .RST({NO{1'b1}})) u_omask (
      .clk(clk), .rst_n(rst_n), .we_i(wr_mko),
      .wdata_i(bus_wdata[NO-1:0]), .mask_o(omask)
   );
   usbirq_maskreg #(.W(NP), .RST({NP{1'b0}})) u_pmask (
      .clk(clk), .rst_n(rst_n), .we_i(wr_pmk),
      .wdata_i(bus_wdata[NP-1:0]), .mask_o(pmask)
   );
   usbirq_maskreg #(.W(1), .RST(1'b0)) u_gen (
      .clk(clk), .rst_n(rst_n), .we_i(wr_gen),
      .wdata_i(bus_wdata[0]), .mask_o(gen_q)
   );

   // Shared flag and request
   usbirq_combine #(.NC(NC), .NI(NI), .NO(NO), .NP(NP)) u_comb (
      .clk        (clk),
      .rst_n      (rst_n),
      .cflag_i    (cflag),
      .cmask_i    (cmask),
      .iflag_i    (iflag),
      .imask_i    (imask),
      .oflag_i    (oflag),
      .omask_i    (omask),
      .pflag_i    (pflag),
      .pmask_i    (pmask),
      .cpf_clr_i  (wr_cpf),
      .gen_i      (gen_q),
      .pending_o  (pending),
      .cpu_flag_o (cpu_flag),
      .irq_o      (irq_req)
   );

   // Read mux
   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         RA_EVC:  bus_rdata[NC-1:0] = cflag;
         RA_EVI:  bus_rdata[NI-1:0] = iflag;
         RA_EVO:  bus_rdata[NO-1:0] = oflag;
         RA_MKC:  bus_rdata[NC-1:0] = cmask;
         RA_MKI:  bus_rdata[NI-1:0] = imask;
         RA_MKO:  bus_rdata[NO-1:0] = omask;
         RA_PFL:  bus_rdata[NP-1:0] = pflag;
         RA_PMK:  bus_rdata[NP-1:0] = pmask;
         RA_GEN:  bus_rdata[0]      = gen_q;
         RA_CPF:  bus_rdata[0]      = cpu_flag;
         default: bus_rdata         = '0;
      endcase
   end
endmodule

// File: rtl/usbirq_chk.sv
module usbirq_chk
   import usbirq_pkg::*;
#(
   parameter int NC     = 6,
   parameter int NI     = 6,
   parameter int NO     = 6,
   parameter int NP     = 8,
   parameter int DP_BIT = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_rd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [NC-1:0]     ev_common,
   input logic [NI-1:0]     ev_in,
   input logic [NO-1:0]     ev_out,
   input logic [NC-1:0]     cflag,
   input logic [NI-1:0]     iflag,
   input logic [NO-1:0]     oflag,
   input logic [NP-1:0]     pflag,
   input logic              dp_fall,
   input logic              pending,
   input logic              gen_en,
   input logic              cpu_flag,
   input logic              irq_req
);
   assert_evset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (|ev_in) |=> ((iflag & $past(ev_in)) == $past(ev_in)));

   assert_rdclr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == RA_EVC && ev_common == '0) |=> (cflag == '0));

   assert_collide_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == RA_EVO && (|ev_out))
      |=> ((oflag & $past(ev_out)) == $past(ev_out)));

   assert_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_flag) |-> $past(pending));

   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pending |=> cpu_flag);

   assert_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (gen_en && cpu_flag));

   assert_dpfall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      dp_fall |=> pflag[DP_BIT]);
endmodule

bind usb_irq_agg usbirq_chk #(
   .NC(NC), .NI(NI), .NO(NO), .NP(NP), .DP_BIT(DP_BIT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_rd    (bus_rd),
   .bus_addr  (bus_addr),
   .ev_common (ev_common),
   .ev_in     (ev_in),
   .ev_out    (ev_out),
   .cflag     (cflag),
   .iflag     (iflag),
   .oflag     (oflag),
   .pflag     (pflag),
   .dp_fall   (dp_fall),
   .pending   (pending),
   .gen_en    (gen_q),
   .cpu_flag  (cpu_flag),
   .irq_req   (irq_req)
);

// File: tb/tb_usb_irq_agg.sv
module tb_usb_irq_agg;
   import usbirq_pkg::*;
   localparam int NC = 6, NI = 6, NO = 6, NP = 8, DW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [NC-1:0] ev_c = '0;
   logic [NI-1:0] ev_i = '0;
   logic [NO-1:0] ev_o = '0;
   logic [NP-1:0] pe   = '0;
   logic          dp   = 1'b1;
   logic          rd   = 1'b0, wr = 1'b0;
   logic [3:0]    addr = '0;
   logic [DW-1:0] wd   = '0;
   wire  [DW-1:0] rdata;
   wire           cpu_flag, irq;

   usb_irq_agg dut (
      .clk(clk), .rst_n(rst_n), .ev_common(ev_c), .ev_in(ev_i), .ev_out(ev_o),
      .port_ev(pe), .dp_pin(dp), .bus_rd(rd), .bus_wr(wr), .bus_addr(addr),
      .bus_wdata(wd), .bus_rdata(rdata), .cpu_flag(cpu_flag), .irq_req(irq)
   );

   // Bench model state
   logic [NC-1:0] m_cf, m_cm;
   logic [NI-1:0] m_if, m_im;
   logic [NO-1:0] m_of, m_om;
   logic [NP-1:0] m_pf, m_pm;
   logic m_gen, m_cpf, m_s0, m_s1, m_prev;
   logic [DW-1:0] last_rd;
   int errs = 0, checks = 0;

   function automatic logic [DW-1:0] exp_rd(logic [3:0] a);
      case (a)
         4'd0: return DW'(m_cf);
         4'd1: return DW'(m_if);
         4'd2: return DW'(m_of);
         4'd3: return DW'(m_cm);
         4'd4: return DW'(m_im);
         4'd5: return DW'(m_om);
         4'd6: return DW'(m_pf);
         4'd7: return DW'(m_pm);
         4'd8: return DW'(m_gen);
         4'd9: return DW'(m_cpf);
         default: return '0;
      endcase
   endfunction

   function automatic string tag_of(logic [3:0] a);
      if (a <= 4'd2) return "R2 flag read";
      if (a <= 4'd5) return "R4 mask read";
      if (a <= 4'd7) return "R9 port read";
      if (a == 4'd8) return "R7 enable read";
      if (a == 4'd9) return "R6 shared flag read";
      return "R10 unused read";
   endfunction

   task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic model_reset();
      m_cf = '0; m_if = '0; m_of = '0; m_pf = '0;
      m_cm = 6'h36; m_im = '1; m_om = '1; m_pm = '0;
      m_gen = 1'b0; m_cpf = 1'b0; m_s0 = 1'b1; m_s1 = 1'b1; m_prev = 1'b1;
   endtask

   task automatic model_edge();
      logic fall, pend;
      fall = m_prev & ~m_s1;
      pend = (|(m_cf & m_cm)) | (|(m_if & m_im)) | (|(m_of & m_om)) | (|(m_pf & m_pm));
      m_cpf = pend | (m_cpf & ~(wr && addr == 4'd9));
      m_cf = ev_c | (m_cf & ~((rd && addr == 4'd0) ? '1 : NC'(0)));
      m_if = ev_i | (m_if & ~((rd && addr == 4'd1) ? '1 : NI'(0)));
      m_of = ev_o | (m_of & ~((rd && addr == 4'd2) ? '1 : NO'(0)));
      m_pf = (pe & 8'h7f) | {fall, 7'h0} | (m_pf & ~((wr && addr == 4'd6) ? wd : 8'h00));
      if (wr && addr == 4'd3) m_cm = wd[NC-1:0];
      if (wr && addr == 4'd4) m_im = wd[NI-1:0];
      if (wr && addr == 4'd5) m_om = wd[NO-1:0];
      if (wr && addr == 4'd7) m_pm = wd;
      if (wr && addr == 4'd8) m_gen = wd[0];
      m_prev = m_s1; m_s1 = m_s0; m_s0 = dp;
   endtask

   // One cycle: drive after falling edge, check, advance
   task automatic step(logic [NC-1:0] c, logic [NI-1:0] i, logic [NO-1:0] o,
                       logic [NP-1:0] p, logic r, logic w, logic [3:0] a,
                       logic [DW-1:0] d);
      ev_c = c; ev_i = i; ev_o = o; pe = p; rd = r; wr = w; addr = a; wd = d;
      #2;
      last_rd = rdata;
      check(tag_of(a), rdata, exp_rd(a));
      check("R5 shared flag", DW'(cpu_flag), DW'(m_cpf));
      check("R7 request", DW'(irq), DW'(m_cpf & m_gen));
      @(posedge clk);
      #1 model_edge();
      @(negedge clk);
   endtask

   task automatic rdreg(logic [3:0] a);
      step('0, '0, '0, '0, 1'b1, 1'b0, a, '0);
   endtask
   task automatic wrreg(logic [3:0] a, logic [DW-1:0] d);
      step('0, '0, '0, '0, 1'b0, 1'b1, a, d);
   endtask
   task automatic idle();
      step('0, '0, '0, '0, 1'b0, 1'b0, 4'd15, '0);
   endtask

   initial begin
      #(20 * 200000);
      errs++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // Reset state
      addr = 4'd3; #2;
      check("R4 common mask reset", rdata, 8'h36);
      @(negedge clk);
      for (int a = 0; a < 16; a++) rdreg(4'(a));

      // R1: set with mask off
      wrreg(4'd4, 8'h00);
      step('0, 6'h05, '0, '0, 1'b0, 1'b0, 4'd15, '0);
      idle();
      check("R1 shared flag stays low when masked", DW'(cpu_flag), 8'h00);
      rdreg(4'd1);
      check("R1 flag set while masked", last_rd, 8'h05);
      rdreg(4'd1);
      check("R2 cleared by read", last_rd, 8'h00);
      wrreg(4'd4, 8'h3f);

      // R3: event during read-clear
      step('0, '0, 6'h03, '0, 1'b0, 1'b0, 4'd15, '0);
      step('0, '0, 6'h30, '0, 1'b1, 1'b0, 4'd2, '0);
      check("R3 read returns old value", last_rd, 8'h03);
      rdreg(4'd2);
      check("R3 new event kept", last_rd, 8'h30);

      // R6 and R7: clear while pending, then drain
      wrreg(4'd9, 8'h00);
      wrreg(4'd8, 8'h01);
      step(6'h02, '0, '0, '0, 1'b0, 1'b0, 4'd15, '0);
      idle();
      check("R7 request with enable", DW'(irq), 8'h01);
      wrreg(4'd9, 8'h00);
      check("R6 flag kept while pending", DW'(cpu_flag), 8'h01);
      rdreg(4'd0);
      wrreg(4'd9, 8'h00);
      idle();
      check("R6 flag cleared when drained", DW'(cpu_flag), 8'h00);
      wrreg(4'd8, 8'h00);

      // R8: D+ falling-edge latency
      dp = 1'b0;
      idle();
      rdreg(4'd6);
      check("R8 no flag after one edge", last_rd & 8'h80, 8'h00);
      rdreg(4'd6);
      check("R8 no flag after two edges", last_rd & 8'h80, 8'h00);
      rdreg(4'd6);
      check("R8 flag after three edges", last_rd & 8'h80, 8'h80);
      wrreg(4'd6, 8'h80);
      dp = 1'b1;
      repeat (4) idle();
      rdreg(4'd6);
      check("R8 rising edge ignored", last_rd, 8'h00);

      // R9: port events, D+ bit of port_ev ignored, write-1-to-clear
      wrreg(4'd7, 8'hff);
      step('0, '0, '0, 8'h81, 1'b0, 1'b0, 4'd15, '0);
      rdreg(4'd6);
      check("R9 port bit set, bit 7 input ignored", last_rd, 8'h01);
      wrreg(4'd6, 8'h01);
      rdreg(4'd6);
      check("R9 write one clears", last_rd, 8'h00);
      wrreg(4'd9, 8'h00);

      // R10: writes to flag registers ignored
      step(6'h09, '0, '0, '0, 1'b0, 1'b0, 4'd15, '0);
      wrreg(4'd0, 8'hff);
      wrreg(4'd0, 8'h00);
      rdreg(4'd0);
      check("R10 flag write ignored", last_rd, 8'h09);

      // Random mix
      for (int n = 0; n < 4000; n++) begin
         logic [3:0] ra;
         logic [1:0] op;
         if ($urandom_range(0, 15) == 0) dp = ~dp;
         ra = 4'($urandom_range(0, 11));
         op = 2'($urandom_range(0, 2));
         step(NC'($urandom & $urandom & $urandom), NI'($urandom & $urandom & $urandom),
              NO'($urandom & $urandom & $urandom), NP'($urandom & $urandom & $urandom),
              op == 2'd1, op == 2'd2, ra, DW'($urandom));
      end

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule